// File: doc/BRIEF.md
# Accumulator ALU with Legacy Status Flags

This block is the combinational arithmetic and logic unit for a small accumulator-style processor with an 8-bit datapath. Each cycle the surrounding core presents an operation code, a register operand, a memory operand, the current carry flag and the decimal-mode flag. The block returns a data result and next values for the negative, overflow, zero and carry flags. Each flag has its own write strobe, so the core updates only the flags that the operation defines and keeps the rest.

Add and subtract always take the incoming carry. For subtract, the carry is an inverted borrow. When decimal mode is on, add and subtract treat each operand as packed two-digit BCD. Compare is a subtraction whose difference is not kept. Bit test reports on the memory operand without changing the register. Shifts, rotates, increment and decrement work on the memory operand, so the core routes the value to be modified onto that port. Register storage, decode and bus timing belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: `op_sel` encoding: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 bit test, 7 shift left, 8 logical shift right, 9 rotate left, 10 rotate right, 11 increment, 12 decrement. Codes 13 to 15 return `reg_a` and raise no flag write strobe.
- R2: Binary add (`dec_mode`=0) gives `result` = (`reg_a` + `mem_b` + `carry_in`) mod 256. C is the carry out of bit 7. All four write strobes are high.
- R3: Binary subtract gives `result` = (`reg_a` − `mem_b` − (1 − `carry_in`)) mod 256. C=1 means no borrow occurred. All four write strobes are high.
- R4: For add and subtract, V=1 exactly when the signed two's-complement result lies outside −128..+127. In decimal mode V is computed from the binary operation on the same inputs. For example, 0x7F+0x01 with C=0 sets V, and 0x81+0xFF with C=0 clears V.
- R5: Decimal add (`dec_mode`=1, valid BCD operands) gives the packed BCD of (a + b + c) mod 100. C=1 when the decimal sum is 100 or more.
- R6: Decimal subtract gives the packed BCD of (a − b − (1 − c)) mod 100. C=0 when the decimal difference is negative.
- R7: Compare returns `reg_a` unchanged. It sets C=1 when `reg_a` ≥ `mem_b` (unsigned), Z=1 on equality and N to bit 7 of (`reg_a` − `mem_b`). Only N, Z and C are written. Carry and decimal inputs are ignored.
- R8: AND, OR and XOR return the bitwise result of `reg_a` and `mem_b`. Only N and Z are written.
- R9: Bit test returns `reg_a`. It sets Z=1 when (`reg_a` AND `mem_b`)=0, N to `mem_b` bit 7 and V to `mem_b` bit 6. C is not written.
- R10: Shift left puts 0 into bit 0 and old bit 7 into C. Logical shift right puts 0 into bit 7 and old bit 0 into C. N, Z and C are written.
- R11: Rotate left puts `carry_in` into bit 0 and old bit 7 into C. Rotate right puts `carry_in` into bit 7 and old bit 0 into C. N, Z and C are written.
- R12: Increment and decrement of `mem_b` wrap modulo 256. Only N and Z are written.
- R13: Wherever N or Z is written, N is bit 7 of `result` and Z is `result`==0, except where R7 or R9 define them otherwise. `dec_mode` has no effect on any operation other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| reg_a | input | 8 | Accumulator or index register operand |
| mem_b | input | 8 | Memory operand; source for unary operations |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal-mode flag |
| result | output | 8 | Data result |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| n_wr | output | 1 | Write strobe for N |
| v_wr | output | 1 | Write strobe for V |
| z_wr | output | 1 | Write strobe for Z |
| c_wr | output | 1 | Write strobe for C |

## Verification
The hardest cases to reach are the decimal digit corrections. A wrong carry between the two digits shows only for particular digit pairs: a low digit sum of exactly 10, or a low borrow feeding a zero high digit. Random byte values rarely form valid BCD, so they seldom hit these pairs. The stimulus therefore walks every pair of valid two-digit BCD operands, with both carry values, for add and for subtract. It also crosses a strided binary grid with the signed-overflow corners 0x7F, 0x80, 0x81 and 0xFF.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_BTST = 4'd6,
      OP_SHL  = 4'd7,
      OP_SHR  = 4'd8,
      OP_RTL  = 4'd9,
      OP_RTR  = 4'd10,
      OP_INC  = 4'd11,
      OP_DEC  = 4'd12
   } alu_op_e;

   localparam int DIGIT_W = 4;

   function automatic logic is_bitwise(alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic is_shift(alu_op_e op);
      return (op == OP_SHL) || (op == OP_SHR) || (op == OP_RTL) || (op == OP_RTR);
   endfunction

   function automatic logic is_step(alu_op_e op);
      return (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   input  logic         dec,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam int DIGITS = W / DIGIT_W;

   logic [W-1:0] b_eff;
   logic [W-1:0] bin_sum;
   logic         bin_cout;
   logic [W-1:0] dec_sum;
   logic         dec_cout;

   // binary path: subtract is add of the inverted operand, carry = not borrow
   assign b_eff = sub ? ~b : b;
   assign {bin_cout, bin_sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   assign ovf = (a[W-1] == b_eff[W-1]) && (bin_sum[W-1] != a[W-1]);

   generate
      if (BCD_EN) begin : g_bcd
         logic [DIGITS:0] chain;
         logic [W-1:0]    digits;

         // per-digit ripple; chain holds carry (add) or borrow (subtract)
         always_comb begin
            logic [DIGIT_W:0] t;
            chain[0] = sub ? ~cin : cin;
            for (int i = 0; i < DIGITS; i++) begin
               if (!sub) begin
                  t = {1'b0, a[DIGIT_W*i +: DIGIT_W]} + {1'b0, b[DIGIT_W*i +: DIGIT_W]}
                      + {{DIGIT_W{1'b0}}, chain[i]};
                  if (t > 5'd9) begin
                     digits[DIGIT_W*i +: DIGIT_W] = t[DIGIT_W-1:0] + 4'd6;
                     chain[i+1] = 1'b1;
                  end else begin
                     digits[DIGIT_W*i +: DIGIT_W] = t[DIGIT_W-1:0];
                     chain[i+1] = 1'b0;
                  end
               end else begin
                  t = {1'b0, a[DIGIT_W*i +: DIGIT_W]} - {1'b0, b[DIGIT_W*i +: DIGIT_W]}
                      - {{DIGIT_W{1'b0}}, chain[i]};
                  if (t[DIGIT_W]) begin
                     digits[DIGIT_W*i +: DIGIT_W] = t[DIGIT_W-1:0] - 4'd6;
                     chain[i+1] = 1'b1;
                  end else begin
                     digits[DIGIT_W*i +: DIGIT_W] = t[DIGIT_W-1:0];
                     chain[i+1] = 1'b0;
                  end
               end
            end
         end

         assign dec_sum  = digits;
         assign dec_cout = sub ? ~chain[DIGITS] : chain[DIGITS];

         // R5 / R6: valid BCD inputs must give valid BCD digits
         always_comb begin
            logic ok_in;
            ok_in = 1'b1;
            for (int i = 0; i < DIGITS; i++) begin
               if (a[DIGIT_W*i +: DIGIT_W] > 4'd9 || b[DIGIT_W*i +: DIGIT_W] > 4'd9) ok_in = 1'b0;
            end
            if (dec && ok_in) begin
               for (int i = 0; i < DIGITS; i++) begin
                  assert_bcd_digit_R5: assert (dec_sum[DIGIT_W*i +: DIGIT_W] <= 4'd9)
                     else $error("decimal digit %0d out of range", i);
               end
            end
         end
      end else begin : g_bin_only
         assign dec_sum  = bin_sum;
         assign dec_cout = bin_cout;
      end
   endgenerate

   assign sum  = (dec && BCD_EN) ? dec_sum  : bin_sum;
   assign cout = (dec && BCD_EN) ? dec_cout : bin_cout;

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         test_zero
);
   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = a;
      endcase
   end

   assign test_zero = ((a & b) == '0);

endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] src,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);
   always_comb begin
      res  = src;
      cout = cin;
      unique case (op)
         OP_SHL: {cout, res} = {src, 1'b0};
         OP_SHR: {res, cout} = {1'b0, src};
         OP_RTL: {cout, res} = {src, cin};
         OP_RTR: {res, cout} = {cin, src};
         OP_INC: res = src + {{(W-1){1'b0}}, 1'b1};
         OP_DEC: res = src - {{(W-1){1'b0}}, 1'b1};
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [3:0]   op_sel,
   input  logic [W-1:0] reg_a,
   input  logic [W-1:0] mem_b,
   input  logic         carry_in,
   input  logic         dec_mode,
   output logic [W-1:0] result,
   output logic         n_out,
   output logic         v_out,
   output logic         z_out,
   output logic         c_out,
   output logic         n_wr,
   output logic         v_wr,
   output logic         z_wr,
   output logic         c_wr
);
   generate
      if ((W % DIGIT_W) != 0 || W < 8) begin : g_bad_width
         $error("acc_alu: W must be a multiple of 4 and at least 8");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic         add_sub, add_cin, add_dec;
   logic [W-1:0] add_sum;
   logic         add_cout, add_ovf;
   logic [W-1:0] log_res;
   logic         log_tz;
   logic [W-1:0] un_res;
   logic         un_cout;

   // compare reuses the subtractor with no borrow in and decimal off
   always_comb begin
      add_sub = (op != OP_ADD);
      add_cin = (op == OP_CMP) ? 1'b1 : carry_in;
      add_dec = (op == OP_CMP) ? 1'b0 : dec_mode;
   end

   acc_alu_adder #(.W(W), .BCD_EN(BCD_EN)) u_adder (
      .a(reg_a), .b(mem_b), .cin(add_cin), .sub(add_sub), .dec(add_dec),
      .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
   );

   acc_alu_logic #(.W(W)) u_logic (
      .op(op), .a(reg_a), .b(mem_b), .res(log_res), .test_zero(log_tz)
   );

   acc_alu_unary #(.W(W)) u_unary (
      .op(op), .src(mem_b), .cin(carry_in), .res(un_res), .cout(un_cout)
   );

   always_comb begin
      result = reg_a;
      n_out  = 1'b0;
      v_out  = 1'b0;
      z_out  = 1'b0;
      c_out  = carry_in;
      {n_wr, v_wr, z_wr, c_wr} = 4'b0000;
      if (op == OP_ADD || op == OP_SUB) begin
         result = add_sum;
         n_out  = add_sum[W-1];
         z_out  = (add_sum == '0);
         v_out  = add_ovf;
         c_out  = add_cout;
         {n_wr, v_wr, z_wr, c_wr} = 4'b1111;
      end else if (op == OP_CMP) begin
         n_out = add_sum[W-1];
         z_out = (add_sum == '0);
         c_out = add_cout;
         {n_wr, v_wr, z_wr, c_wr} = 4'b1011;
      end else if (is_bitwise(op)) begin
         result = log_res;
         n_out  = log_res[W-1];
         z_out  = (log_res == '0);
         {n_wr, v_wr, z_wr, c_wr} = 4'b1010;
      end else if (op == OP_BTST) begin
         n_out = mem_b[W-1];
         v_out = mem_b[W-2];
         z_out = log_tz;
         {n_wr, v_wr, z_wr, c_wr} = 4'b1110;
      end else if (is_shift(op)) begin
         result = un_res;
         n_out  = un_res[W-1];
         z_out  = (un_res == '0);
         c_out  = un_cout;
         {n_wr, v_wr, z_wr, c_wr} = 4'b1011;
      end else if (is_step(op)) begin
         result = un_res;
         n_out  = un_res[W-1];
         z_out  = (un_res == '0);
         {n_wr, v_wr, z_wr, c_wr} = 4'b1010;
      end
   end

   always_comb begin
      if (op_sel > 4'd12) begin
         assert_unused_quiet_R1: assert (!n_wr && !v_wr && !z_wr && !c_wr && result == reg_a)
            else $error("unused code wrote flags");
      end
      if (op == OP_CMP) begin
         assert_cmp_order_R7: assert (result == reg_a && !v_wr &&
                                      c_out == (reg_a >= mem_b) && z_out == (reg_a == mem_b))
            else $error("compare flags wrong");
      end
      if (is_bitwise(op) || is_shift(op) || is_step(op)) begin
         assert_v_kept_R8: assert (!v_wr) else $error("V written by non-arithmetic op");
      end
      if (op == OP_BTST) begin
         assert_bit_copy_R9: assert (n_out == mem_b[W-1] && v_out == mem_b[W-2] &&
                                     result == reg_a && !c_wr)
            else $error("bit test flags wrong");
      end
      if (op == OP_SHL) begin
         assert_shl_carry_R10: assert (c_out == mem_b[W-1] && !result[0])
            else $error("shift left carry wrong");
      end
      if (op == OP_SHR) begin
         assert_shr_carry_R10: assert (c_out == mem_b[0] && !result[W-1])
            else $error("shift right carry wrong");
      end
   end

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [3:0] op_sel;
   logic [7:0] reg_a, mem_b, result;
   logic       carry_in, dec_mode;
   logic       n_out, v_out, z_out, c_out, n_wr, v_wr, z_wr, c_wr;

   acc_alu dut (
      .op_sel(op_sel), .reg_a(reg_a), .mem_b(mem_b), .carry_in(carry_in), .dec_mode(dec_mode),
      .result(result), .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out),
      .n_wr(n_wr), .v_wr(v_wr), .z_wr(z_wr), .c_wr(c_wr)
   );

   typedef struct {
      logic [3:0] op;
      logic [7:0] a, b;
      logic [7:0] res;
      logic [7:0] fl;   // {n,v,z,c,wn,wv,wz,wc}, unwritten flags masked to 0
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic int bcd2int(logic [7:0] x);
      return int'(x[7:4]) * 10 + int'(x[3:0]);
   endfunction

   function automatic logic [7:0] int2bcd(int x);
      logic [7:0] r;
      r[7:4] = 4'((x / 10) % 10);
      r[3:0] = 4'(x % 10);
      return r;
   endfunction

   function automatic exp_t model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic d);
      exp_t e;
      int s, sa, sb, sv;
      logic n, v, z, co;
      logic [3:0] w;
      n = 0; v = 0; z = 0; co = 0; w = 4'b0000;
      e.res = a;
      sa = int'($signed(a));
      sb = int'($signed(b));
      case (op)
         4'd0: begin
            if (d) begin
               s = bcd2int(a) + bcd2int(b) + int'(c);
               co = (s >= 100); e.res = int2bcd(s % 100);
            end else begin
               s = int'(a) + int'(b) + int'(c);
               co = (s > 255); e.res = 8'(s);
            end
            sv = sa + sb + int'(c);
            v = (sv > 127) || (sv < -128);
            w = 4'b1111;
         end
         4'd1: begin
            if (d) begin
               s = bcd2int(a) - bcd2int(b) - (1 - int'(c));
               co = (s >= 0);
               if (s < 0) s = s + 100;
               e.res = int2bcd(s);
            end else begin
               s = int'(a) - int'(b) - (1 - int'(c));
               co = (s >= 0); e.res = 8'(s);
            end
            sv = sa - sb - (1 - int'(c));
            v = (sv > 127) || (sv < -128);
            w = 4'b1111;
         end
         4'd2: begin
            s = int'(a) - int'(b);
            n = s[7]; z = (a == b); co = (a >= b); w = 4'b1011;
         end
         4'd3: begin e.res = a & b; w = 4'b1010; end
         4'd4: begin e.res = a | b; w = 4'b1010; end
         4'd5: begin e.res = a ^ b; w = 4'b1010; end
         4'd6: begin n = b[7]; v = b[6]; z = ((a & b) == 0); w = 4'b1110; end
         4'd7: begin e.res = {b[6:0], 1'b0}; co = b[7]; w = 4'b1011; end
         4'd8: begin e.res = {1'b0, b[7:1]}; co = b[0]; w = 4'b1011; end
         4'd9: begin e.res = {b[6:0], c}; co = b[7]; w = 4'b1011; end
         4'd10: begin e.res = {c, b[7:1]}; co = b[0]; w = 4'b1011; end
         4'd11: begin e.res = b + 8'd1; w = 4'b1010; end
         4'd12: begin e.res = b - 8'd1; w = 4'b1010; end
         default: ;
      endcase
      if (op != 4'd2 && op != 4'd6) begin
         n = e.res[7];
         z = (e.res == 0);
      end
      e.fl = {n & w[3], v & w[2], z & w[1], co & w[0], w};
      return e;
   endfunction

   function automatic string tag_of(logic [3:0] op, logic d);
      case (op)
         4'd0: return d ? "R5" : "R2";
         4'd1: return d ? "R6" : "R3";
         4'd2: return "R7";
         4'd3, 4'd4, 4'd5: return "R8";
         4'd6: return "R9";
         4'd7, 4'd8: return "R10";
         4'd9, 4'd10: return "R11";
         4'd11, 4'd12: return "R12";
         default: return "R1";
      endcase
   endfunction

   task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic d, string tag);
      exp_t e;
      @(posedge clk);
      #1;
      op_sel = op; reg_a = a; mem_b = b; carry_in = c; dec_mode = d;
      e = model(op, a, b, c, d);
      e.op = op; e.a = a; e.b = b; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: outputs settled since the drive at posedge+1
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         logic [7:0] got_fl;
         e = sb_q.pop_front();
         got_fl = {n_out & n_wr, v_out & v_wr, z_out & z_wr, c_out & c_wr, n_wr, v_wr, z_wr, c_wr};
         checks++;
         if (result !== e.res || got_fl !== e.fl) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h fl=%b expected res=%h fl=%b",
                     e.tag, e.op, e.a, e.b, result, got_fl, e.res, e.fl);
         end
      end
   end

   initial begin
      op_sel = 4'd0; reg_a = 8'h00; mem_b = 8'h00; carry_in = 1'b0; dec_mode = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      // reset state: idle inputs give a zero add
      drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
      // R4 signed overflow corners
      drive(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, "R4");
      drive(4'd0, 8'h81, 8'hFF, 1'b0, 1'b0, "R4");
      drive(4'd0, 8'h80, 8'h80, 1'b0, 1'b0, "R4");
      drive(4'd1, 8'h80, 8'h01, 1'b1, 1'b0, "R4");
      drive(4'd1, 8'h7F, 8'hFF, 1'b1, 1'b0, "R4");
      drive(4'd0, 8'h79, 8'h01, 1'b0, 1'b1, "R4");
      // R1 unused codes
      for (int op = 13; op < 16; op++) begin
         drive(4'(op), 8'h5A, 8'hC3, 1'b1, 1'b0, "R1");
         drive(4'(op), 8'h00, 8'hFF, 1'b0, 1'b1, "R1");
      end
      // two-operand ops, binary mode, strided grid plus corners
      for (int op = 0; op < 7; op++) begin
         for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 3) begin
               drive(4'(op), 8'(a), 8'(b), 1'b0, 1'b0, tag_of(4'(op), 1'b0));
               drive(4'(op), 8'(a), 8'(b), 1'b1, 1'b0, tag_of(4'(op), 1'b0));
            end
         end
         drive(4'(op), 8'hFF, 8'hFF, 1'b1, 1'b0, tag_of(4'(op), 1'b0));
         drive(4'(op), 8'h80, 8'h7F, 1'b0, 1'b0, tag_of(4'(op), 1'b0));
      end
      // unary ops exhaustive
      for (int op = 7; op < 13; op++) begin
         for (int b = 0; b < 256; b++) begin
            drive(4'(op), 8'h33, 8'(b), 1'b0, 1'b0, tag_of(4'(op), 1'b0));
            drive(4'(op), 8'hCC, 8'(b), 1'b1, 1'b0, tag_of(4'(op), 1'b0));
         end
      end
      // decimal add and subtract over every valid BCD pair
      for (int op = 0; op < 2; op++) begin
         for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
               drive(4'(op), int2bcd(a), int2bcd(b), 1'b0, 1'b1, tag_of(4'(op), 1'b1));
               drive(4'(op), int2bcd(a), int2bcd(b), 1'b1, 1'b1, tag_of(4'(op), 1'b1));
            end
         end
      end
      // R13: decimal flag ignored outside add/subtract
      for (int op = 2; op < 13; op++) begin
         for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 15) begin
               drive(4'(op), 8'(a), 8'(b), 1'(a[4]), 1'b1, "R13");
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      #1;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule